// File: doc/BRIEF.md
# Serial Control Slave with Colour Table and Cursor Ports

This block is the two-wire serial control port of a display pipeline. It watches the SCL and SDA lines through a system clock, answers one fixed device address, and turns each bus transfer into accesses to three kinds of storage. The first is a small file of control registers that the rest of the chip reads in parallel. The second is a 256-entry colour table that returns a 24-bit red/green/blue value for each index. The third is a 256-byte cursor bitmap. Two read-only status bytes, supplied from outside, sit just above the control registers.

The first byte after the device address is a subaddress. For the control registers, the subaddress moves up by one after every data byte, written or read. Two subaddresses at the top of the range are not registers. Each opens an indirect streaming port. After subaddress FFh, the next byte sets the colour-table index, and each group of three bytes after it fills one entry in red, green, blue order. The index moves up once a whole entry is written. Subaddress FEh works the same way for the cursor bitmap, with one byte per index, so that index moves up after every byte.

The pixel side reads both tables through their own read-address ports. A register read-back is done with a write of the subaddress, a repeated START, and a read transfer.

Top module: `i2c_lut_slave`

## Requirements
- R1: The slave pulls SDA low in the acknowledge slot only after an address byte whose upper seven bits equal 44h (88h for a write, 89h for a read). Any other address gets no acknowledge, and the rest of that transfer changes nothing.
- R2: In a write transfer, the first data byte is taken as the subaddress. Each later byte goes to the control register at the current subaddress, and the subaddress then moves up by one. Register k appears on `ctrl_o[8k+7:8k]`, and every data byte gets an acknowledge.
- R3: Subaddress NUM_CTRL (0Eh by default) reads `status_i[7:0]`, and NUM_CTRL+1 (0Fh) reads `status_i[15:8]`. Writes to these two, and to any unused subaddress, change no state. Unused subaddresses read 00h.
- R4: A read transfer after a repeated START returns the byte at the current subaddress MSB first, and moves the subaddress up by one after each byte. When the master does not acknowledge a byte, the slave stops driving SDA and the read ends.
- R5: After subaddress FFh, the next byte sets the colour-table index. The bytes after it are written as red, green, blue into that entry, and the index moves up by one after each blue byte. `lut_rdata_o` shows red in bits 23:16, green in 15:8 and blue in 7:0.
- R6: After subaddress FEh, the next byte sets the cursor index. Each byte after it is written to the cursor bitmap, and the index moves up by one (modulo 256) after every byte.
- R7: Every START and STOP sets the colour position back to red, so a partial entry left by one transfer does not shift the colours of the next.
- R8: SDA is driven low only in acknowledge slots and for zero bits of read data. A drive only begins while SCL is low, and SDA is released at every STOP and whenever no transfer is in progress.
- R9: After reset, SDA is released and every control register holds 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least ten times the bus bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | High to pull the data line low (open drain) |
| status_i | input | 16 | Two read-only status bytes |
| ctrl_o | output | NUM_CTRL*8 | Control register contents, register k in bits 8k+7:8k |
| lut_raddr_i | input | TAB_AW | Colour-table read index |
| lut_rdata_o | output | 24 | Colour entry at `lut_raddr_i`: red, green, blue from MSB |
| cur_raddr_i | input | TAB_AW | Cursor bitmap read index |
| cur_rdata_o | output | 8 | Cursor byte at `cur_raddr_i` |

## Verification
The bound checker watches the bus-driving rules on every cycle. A new SDA drive only starts while SCL is low, SDA is released at STOP and whenever the engine is idle, and the colour position always lies in the range red to blue. It also checks that at most one colour bank is written per cycle, that the cursor is never written in the same cycle as a colour bank, and that a START always puts the colour position back on red. Whether the right bytes land in the right registers and entries can only be shown by the bench scenarios. These cover address match and mismatch, subaddress auto-increment in both directions, status bytes that ignore writes, index wrap in the cursor port, and a partial colour entry followed by a new transfer. All of them are read back through the bus or the table read ports.

// File: rtl/i2c_lut_pkg.sv
// Package: shared constants and types for the serial control slave.
// Assumes an 8-bit subaddress space with the top two codes reserved as ports.
package i2c_lut_pkg;

    localparam logic [6:0] DEV_ADDR     = 7'h44;
    localparam logic [7:0] SUB_LUT_PORT = 8'hFF;
    localparam logic [7:0] SUB_CUR_PORT = 8'hFE;

    typedef enum logic [2:0] {
        BS_IDLE,
        BS_ADDR,
        BS_ADDR_ACK,
        BS_WR,
        BS_WR_ACK,
        BS_RD,
        BS_RD_ACK
    } bus_state_e;

    typedef enum logic [1:0] {
        PM_REG,
        PM_LUT,
        PM_CUR
    } port_mode_e;

    typedef struct packed {
        logic       valid;
        logic       is_sub;
        logic [7:0] data;
    } wr_beat_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Module: brings SCL/SDA into the clk domain through a flip-flop chain and
// derives SCL edges plus START/STOP events.
// Assumes STAGES >= 2 and clk at least ten times the bus bit rate.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;

    // Synchronise both lines and keep one extra sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_bit_engine.sv
// Module: bit-level slave protocol engine. It shifts in address and write
// bytes on SCL rise, drives ACK and read bits after SCL fall, and reports
// write bytes and read advances to the register map.
// Assumes synchronised inputs from i2c_line_sync; no clock stretching.
module i2c_bit_engine
    import i2c_lut_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_evt,
    input  logic       stop_evt,
    input  logic [7:0] rd_data,
    output logic       sda_oe,
    output wr_beat_t   wr_beat,
    output logic       rd_next,
    output logic       busy
);

    bus_state_e state;
    logic [3:0] cnt;
    logic [7:0] shreg;
    logic       rw;
    logic       first;
    logic       nack;

    // Protocol state machine, one bus event per cycle at most.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= BS_IDLE;
            cnt     <= '0;
            shreg   <= '0;
            rw      <= 1'b0;
            first   <= 1'b0;
            nack    <= 1'b0;
            sda_oe  <= 1'b0;
            wr_beat <= '0;
            rd_next <= 1'b0;
        end else begin
            wr_beat.valid <= 1'b0;
            rd_next       <= 1'b0;
            if (start_evt) begin
                state  <= BS_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (stop_evt) begin
                state  <= BS_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    BS_ADDR, BS_WR: begin
                        if (scl_rise && cnt != 4'd8) begin
                            shreg <= {shreg[6:0], sda_s};
                            cnt   <= cnt + 4'd1;
                        end else if (scl_fall && cnt == 4'd8) begin
                            cnt <= '0;
                            if (state == BS_ADDR) begin
                                if (shreg[7:1] == DEV_ADDR) begin
                                    sda_oe <= 1'b1;
                                    rw     <= shreg[0];
                                    state  <= BS_ADDR_ACK;
                                end else begin
                                    state <= BS_IDLE;
                                end
                            end else begin
                                sda_oe  <= 1'b1;
                                state   <= BS_WR_ACK;
                                wr_beat <= '{valid: 1'b1, is_sub: first, data: shreg};
                                first   <= 1'b0;
                            end
                        end
                    end
                    BS_ADDR_ACK: begin
                        if (scl_fall) begin
                            if (rw) begin
                                state  <= BS_RD;
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[7];
                                cnt    <= '0;
                            end else begin
                                state  <= BS_WR;
                                sda_oe <= 1'b0;
                                first  <= 1'b1;
                            end
                        end
                    end
                    BS_WR_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= BS_WR;
                        end
                    end
                    BS_RD: begin
                        if (scl_fall) begin
                            if (cnt == 4'd7) begin
                                sda_oe  <= 1'b0;
                                rd_next <= 1'b1;
                                state   <= BS_RD_ACK;
                            end else begin
                                cnt    <= cnt + 4'd1;
                                shreg  <= {shreg[6:0], 1'b0};
                                sda_oe <= ~shreg[6];
                            end
                        end
                    end
                    BS_RD_ACK: begin
                        if (scl_rise) begin
                            nack <= sda_s;
                        end else if (scl_fall) begin
                            if (nack) begin
                                state <= BS_IDLE;
                            end else begin
                                state  <= BS_RD;
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[7];
                                cnt    <= '0;
                            end
                        end
                    end
                    default: state <= BS_IDLE;
                endcase
            end
        end
    end

    assign busy = (state != BS_IDLE);

endmodule

// File: rtl/i2c_reg_map.sv
// Module: subaddress decoder. It holds the control registers, steers write
// bytes to registers or to the colour-table and cursor ports, keeps the
// table indices and colour position, and muxes read data.
// Assumes NUM_CTRL + 2 < 254 and TAB_AW <= 8.
module i2c_reg_map
    import i2c_lut_pkg::*;
#(
    parameter int NUM_CTRL = 14,
    parameter int TAB_AW   = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  wr_beat_t              wr_beat,
    input  logic                  rd_next,
    input  logic                  xfer_edge,
    input  logic [15:0]           status_i,
    output logic [7:0]            rd_data,
    output logic [NUM_CTRL*8-1:0] ctrl_o,
    output logic [2:0]            lut_we,
    output logic [TAB_AW-1:0]     lut_waddr,
    output logic                  cur_we,
    output logic [TAB_AW-1:0]     cur_waddr,
    output logic [7:0]            tab_wdata,
    output logic [1:0]            color_idx
);

    localparam int STAT_LO = NUM_CTRL;
    localparam int STAT_HI = NUM_CTRL + 1;

    logic [7:0]        ptr;
    port_mode_e        mode;
    logic              addr_pend;
    logic [1:0]        color;
    logic [TAB_AW-1:0] lut_ptr;
    logic [TAB_AW-1:0] cur_ptr;
    logic [7:0]        ctrl_q [NUM_CTRL];
    logic              data_beat;

    assign data_beat = wr_beat.valid && !wr_beat.is_sub;

    // Subaddress, port mode, table indices and colour position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr       <= '0;
            mode      <= PM_REG;
            addr_pend <= 1'b0;
            color     <= '0;
            lut_ptr   <= '0;
            cur_ptr   <= '0;
        end else begin
            if (xfer_edge) begin
                color <= '0;
            end
            if (wr_beat.valid && wr_beat.is_sub) begin
                ptr       <= wr_beat.data;
                addr_pend <= 1'b1;
                mode      <= (wr_beat.data == SUB_LUT_PORT) ? PM_LUT :
                             (wr_beat.data == SUB_CUR_PORT) ? PM_CUR : PM_REG;
            end else if (data_beat) begin
                case (mode)
                    PM_LUT: begin
                        if (addr_pend) begin
                            lut_ptr   <= wr_beat.data[TAB_AW-1:0];
                            addr_pend <= 1'b0;
                            color     <= '0;
                        end else if (color == 2'd2) begin
                            color   <= '0;
                            lut_ptr <= lut_ptr + 1'b1;
                        end else begin
                            color <= color + 2'd1;
                        end
                    end
                    PM_CUR: begin
                        if (addr_pend) begin
                            cur_ptr   <= wr_beat.data[TAB_AW-1:0];
                            addr_pend <= 1'b0;
                        end else begin
                            cur_ptr <= cur_ptr + 1'b1;
                        end
                    end
                    default: ptr <= ptr + 8'd1;
                endcase
            end else if (rd_next && mode == PM_REG) begin
                ptr <= ptr + 8'd1;
            end
        end
    end

    // One writable register per control slot.
    for (genvar i = 0; i < NUM_CTRL; i++) begin : g_ctrl
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctrl_q[i] <= '0;
            end else if (data_beat && mode == PM_REG && ptr == 8'(i)) begin
                ctrl_q[i] <= wr_beat.data;
            end
        end
        assign ctrl_o[i*8 +: 8] = ctrl_q[i];
    end

    // Table write strobes: one bank or the cursor per data byte.
    always_comb begin
        lut_we = '0;
        cur_we = 1'b0;
        if (data_beat && !addr_pend) begin
            if (mode == PM_LUT) begin
                lut_we = 3'b001 << color;
            end else if (mode == PM_CUR) begin
                cur_we = 1'b1;
            end
        end
    end

    // Read mux over control registers and status bytes.
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_CTRL; k++) begin
            if (ptr == 8'(k)) begin
                rd_data = ctrl_q[k];
            end
        end
        if (ptr == 8'(STAT_LO)) begin
            rd_data = status_i[7:0];
        end
        if (ptr == 8'(STAT_HI)) begin
            rd_data = status_i[15:8];
        end
    end

    assign lut_waddr = lut_ptr;
    assign cur_waddr = cur_ptr;
    assign tab_wdata = wr_beat.data;
    assign color_idx = color;

endmodule

// File: rtl/i2c_lut_tables.sv
// Module: colour-table banks (red, green, blue) and the cursor bitmap, with
// one write port fed by the register map and asynchronous pixel-side reads.
// Assumes storage needs no reset; contents are undefined until written.
module i2c_lut_tables #(
    parameter int TAB_AW = 8
) (
    input  logic              clk,
    input  logic [2:0]        lut_we,
    input  logic [TAB_AW-1:0] lut_waddr,
    input  logic              cur_we,
    input  logic [TAB_AW-1:0] cur_waddr,
    input  logic [7:0]        wdata,
    input  logic [TAB_AW-1:0] lut_raddr,
    input  logic [TAB_AW-1:0] cur_raddr,
    output logic [23:0]       lut_rdata,
    output logic [7:0]        cur_rdata
);

    localparam int DEPTH = 1 << TAB_AW;

    // Bank 0 holds red (top byte), bank 2 holds blue (bottom byte).
    for (genvar b = 0; b < 3; b++) begin : g_bank
        logic [7:0] mem [DEPTH];
        // Byte write into this colour bank.
        always_ff @(posedge clk) begin
            if (lut_we[b]) begin
                mem[lut_waddr] <= wdata;
            end
        end
        assign lut_rdata[(2-b)*8 +: 8] = mem[lut_raddr];
    end

    logic [7:0] cur_mem [DEPTH];

    // Byte write into the cursor bitmap.
    always_ff @(posedge clk) begin
        if (cur_we) begin
            cur_mem[cur_waddr] <= wdata;
        end
    end

    assign cur_rdata = cur_mem[cur_raddr];

endmodule

// File: rtl/i2c_lut_slave.sv
// Module: top of the serial control slave. Wires the line synchroniser, the
// protocol engine, the subaddress map and the table storage together.
// Assumes an external open-drain pad: sda_oe_o high pulls SDA low.
module i2c_lut_slave
    import i2c_lut_pkg::*;
#(
    parameter int NUM_CTRL    = 14,
    parameter int TAB_AW      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    input  logic [15:0]           status_i,
    output logic [NUM_CTRL*8-1:0] ctrl_o,
    input  logic [TAB_AW-1:0]     lut_raddr_i,
    output logic [23:0]           lut_rdata_o,
    input  logic [TAB_AW-1:0]     cur_raddr_i,
    output logic [7:0]            cur_rdata_o
);

    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_evt;
    logic              stop_evt;
    logic [7:0]        rd_data;
    wr_beat_t          wr_beat;
    logic              rd_next;
    logic              eng_busy;
    logic [2:0]        lut_we;
    logic [TAB_AW-1:0] lut_waddr;
    logic              cur_we;
    logic [TAB_AW-1:0] cur_waddr;
    logic [7:0]        tab_wdata;
    logic [1:0]        color_idx;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    i2c_bit_engine u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .rd_data   (rd_data),
        .sda_oe    (sda_oe_o),
        .wr_beat   (wr_beat),
        .rd_next   (rd_next),
        .busy      (eng_busy)
    );

    i2c_reg_map #(.NUM_CTRL(NUM_CTRL), .TAB_AW(TAB_AW)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_beat   (wr_beat),
        .rd_next   (rd_next),
        .xfer_edge (start_evt | stop_evt),
        .status_i  (status_i),
        .rd_data   (rd_data),
        .ctrl_o    (ctrl_o),
        .lut_we    (lut_we),
        .lut_waddr (lut_waddr),
        .cur_we    (cur_we),
        .cur_waddr (cur_waddr),
        .tab_wdata (tab_wdata),
        .color_idx (color_idx)
    );

    i2c_lut_tables #(.TAB_AW(TAB_AW)) u_tables (
        .clk       (clk),
        .lut_we    (lut_we),
        .lut_waddr (lut_waddr),
        .cur_we    (cur_we),
        .cur_waddr (cur_waddr),
        .wdata     (tab_wdata),
        .lut_raddr (lut_raddr_i),
        .cur_raddr (cur_raddr_i),
        .lut_rdata (lut_rdata_o),
        .cur_rdata (cur_rdata_o)
    );

endmodule

// File: rtl/i2c_lut_slave_chk.sv
// Module: protocol and port checker, bound into i2c_lut_slave.
// Assumes the top's internal net names listed in the bind below.
module i2c_lut_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe,
    input logic       busy,
    input logic       start_evt,
    input logic       stop_evt,
    input logic [1:0] color_idx,
    input logic [2:0] lut_we,
    input logic       cur_we
);

    // A new SDA drive only begins while the bus clock is low.
    assert_oe_rise_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);

    // No drive when the engine is idle.
    assert_idle_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sda_oe);

    // STOP releases the line and returns the engine to idle.
    assert_stop_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (!sda_oe && !busy));

    // Colour position never leaves red..blue.
    assert_color_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        color_idx != 2'd3);

    // At most one colour bank written per byte.
    assert_bank_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lut_we));

    // Cursor and colour table never written together.
    assert_port_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cur_we && (lut_we != 3'b000)));

    // START puts the colour position back on red.
    assert_start_red_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (color_idx == 2'd0));

endmodule

bind i2c_lut_slave i2c_lut_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe_o),
    .busy      (eng_busy),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .color_idx (color_idx),
    .lut_we    (lut_we),
    .cur_we    (cur_we)
);

// File: tb/tb_i2c_lut_slave.sv
// Bench: bus driver tasks push expected/observed pairs into a scoreboard
// queue; a monitor process pops and compares them.
`timescale 1ns/1ps
module tb_i2c_lut_slave;

    localparam int Q = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         scl = 1'b1;
    logic         sda_m = 1'b1;
    logic         sda_oe;
    logic [15:0]  status = 16'hBEEF;
    logic [111:0] ctrl;
    logic [7:0]   lut_raddr = '0;
    logic [23:0]  lut_rdata;
    logic [7:0]   cur_raddr = '0;
    logic [7:0]   cur_rdata;
    wire          sda_bus = sda_m & ~sda_oe;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 0;

    typedef struct {
        string       req;
        logic [31:0] got;
        logic [31:0] exp;
    } item_t;
    item_t sb_q[$];

    always #2 clk = ~clk;

    i2c_lut_slave dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl),
        .sda_i       (sda_bus),
        .sda_oe_o    (sda_oe),
        .status_i    (status),
        .ctrl_o      (ctrl),
        .lut_raddr_i (lut_raddr),
        .lut_rdata_o (lut_rdata),
        .cur_raddr_i (cur_raddr),
        .cur_rdata_o (cur_rdata)
    );

    // Monitor: pop scoreboard items and compare.
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                total++;
                if (it.got !== it.exp) begin
                    bad++;
                    $display("FAIL %s got=%0h exp=%0h", it.req, it.got, it.exp);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog got=hang exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic push(input string req, input logic [31:0] got, input logic [31:0] exp);
        item_t it;
        it.req = req;
        it.got = got;
        it.exp = exp;
        sb_q.push_back(it);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b0; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;  tick(Q);
        scl = 1'b1; tick(2*Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        b = sda_bus;  tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack_n);
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        get_bit(ack_n);
    endtask

    task automatic get_byte(input logic nack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            get_bit(b);
            d[i] = b;
        end
        send_bit(nack);
    endtask

    // Write transfer: address 88h, subaddress, then n bytes from MSB of data.
    task automatic write_seq(input string req, input logic [7:0] sub,
                             input logic [63:0] data, input int n);
        logic a;
        bus_start();
        send_byte(8'h88, a);
        push("R1 address ack", {31'b0, a}, 32'd0);
        send_byte(sub, a);
        push({req, " subaddress ack"}, {31'b0, a}, 32'd0);
        for (int k = 0; k < n; k++) begin
            send_byte(data[63-8*k -: 8], a);
            push({req, " data ack"}, {31'b0, a}, 32'd0);
        end
        bus_stop();
        push("R8 released after stop", {31'b0, sda_oe}, 32'd0);
    endtask

    // Read-back: set subaddress, repeated START, read n bytes, NACK the last.
    task automatic read_seq(input string req, input logic [7:0] sub,
                            input int n, input logic [31:0] exp);
        logic       a;
        logic [7:0] d;
        bus_start();
        send_byte(8'h88, a);
        send_byte(sub, a);
        bus_start();
        send_byte(8'h89, a);
        push("R1 read address ack", {31'b0, a}, 32'd0);
        for (int k = 0; k < n; k++) begin
            get_byte(k == n-1, d);
            push({req, " read byte"}, {24'b0, d}, {24'b0, exp[8*(n-1-k) +: 8]});
        end
        tick(4);
        push("R4 released after master NACK", {31'b0, sda_oe}, 32'd0);
        bus_stop();
    endtask

    initial begin
        logic a;
        tick(5);
        push("R9 sda released in reset", {31'b0, sda_oe}, 32'd0);
        rst_n = 1'b1;
        tick(3);
        push("R9 ctrl cleared", {31'b0, |ctrl}, 32'd0);
        push("R9 sda released", {31'b0, sda_oe}, 32'd0);

        // R2: auto-incrementing register write.
        write_seq("R2", 8'h00, 64'hA1B2C3_0000000000, 3);
        push("R2 reg0", {24'b0, ctrl[7:0]},   32'hA1);
        push("R2 reg1", {24'b0, ctrl[15:8]},  32'hB2);
        push("R2 reg2", {24'b0, ctrl[23:16]}, 32'hC3);

        // R1: wrong address is ignored.
        bus_start();
        send_byte(8'h8A, a);
        push("R1 no ack for 45h", {31'b0, a}, 32'd1);
        send_byte(8'h00, a);
        push("R1 no ack after mismatch", {31'b0, a}, 32'd1);
        send_byte(8'h5A, a);
        bus_stop();
        push("R1 reg0 untouched", {24'b0, ctrl[7:0]}, 32'hA1);

        // R3: status bytes ignore writes and read back status_i.
        write_seq("R3", 8'h0D, 64'h771234_0000000000, 3);
        push("R3 reg13", {24'b0, ctrl[111:104]}, 32'h77);
        read_seq("R3", 8'h0D, 3, 32'h0077EFBE);
        read_seq("R3 unused", 8'h20, 2, 32'h00000000);

        // R4: read-back with auto-increment.
        read_seq("R4", 8'h00, 3, 32'h00A1B2C3);

        // R5: colour-table triplets.
        write_seq("R5", 8'hFF, 64'h10112233445566_00, 7);
        lut_raddr = 8'h10; tick(1);
        push("R5 entry 10h", {8'b0, lut_rdata}, 32'h00112233);
        lut_raddr = 8'h11; tick(1);
        push("R5 entry 11h", {8'b0, lut_rdata}, 32'h00445566);

        // R6: cursor bytes with index wrap.
        write_seq("R6", 8'hFE, 64'hFE9ABCDE_00000000, 4);
        cur_raddr = 8'hFE; tick(1);
        push("R6 cursor FEh", {24'b0, cur_rdata}, 32'h9A);
        cur_raddr = 8'hFF; tick(1);
        push("R6 cursor FFh", {24'b0, cur_rdata}, 32'hBC);
        cur_raddr = 8'h00; tick(1);
        push("R6 cursor 00h", {24'b0, cur_rdata}, 32'hDE);

        // R7: partial entry, then a new transfer starts at red.
        write_seq("R7", 8'hFF, 64'h200102_0000000000, 3);
        write_seq("R7", 8'hFF, 64'h21AABBCC_00000000, 4);
        lut_raddr = 8'h21; tick(1);
        push("R7 entry 21h", {8'b0, lut_rdata}, 32'h00AABBCC);
        lut_raddr = 8'h20; tick(1);
        push("R7 partial 20h red/green", {16'b0, lut_rdata[23:8]}, 32'h00000102);
        push("R8 idle release", {31'b0, sda_oe}, 32'd0);

        tick(10);
        while (sb_q.size() > 0) tick(1);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule